// File: doc/BRIEF.md
# First-Order Requantizing Noise-Shaping Stage

This block is a single first-order error-feedback loop meant to sit behind another noise-shaping loop in a multistage converter. Each oversampled clock that carries a valid strobe, the block takes in the truncation error handed down by the preceding loop. It adds that error to the residual it kept from the previous sample. The 22-bit total is then turned into a coarse 8-bit two's-complement code.

The coarse code comes from a window of the sum that starts at bit 12. When the bits above that window are not plain sign extension, the code clamps to the nearest end of the 8-bit range, so the quantizer also limits amplitude. The part of the sum that the code does not account for becomes the new stored residual. This residual also leaves the block on its own port, so an identical copy can be placed after it to form a deeper cascade. The output code feeds an external error-cancellation network, which is not part of this block.

Top module: `rq_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `code_o` and `resid_o` become zero after that edge, whatever `in_valid` and `err_i` are.
- R2: On a valid edge the block forms the sum of `err_i` and the current `resid_o`, both signed 22-bit. The addition wraps modulo 2^22 as two's complement.
- R3: When bits 21, 20 and 19 of the sum are all equal, the next `code_o` equals bits 19 down to 12 of the sum, read as a signed 8-bit value.
- R4: When the sum is non-negative but bits 21..19 are not all equal, the next `code_o` is 8'h7F (+127).
- R5: When the sum is negative but bits 21..19 are not all equal, the next `code_o` is 8'h80 (-128).
- R6: The next `resid_o` equals the sum minus `code_o` multiplied by 4096. When the sum is unclipped, this value lies in 0..4095.
- R7: On an edge where `in_valid` is low, `code_o` and `resid_o` keep their values and `err_i` has no effect.
- R8: `code_o` and `resid_o` are registers. A valid sample presented before an edge shows on them only after that edge.
- R9: Start from reset and apply N valid samples of a constant input C that never clips. Then 4096 times the sum of the N codes, plus the final `resid_o`, equals N·C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampled clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; the loop advances only on edges where it is high |
| err_i | input | 22 | Signed error word from the preceding loop |
| code_o | output | 8 | Signed quantized and clamped output code |
| resid_o | output | 22 | Signed residual kept by the loop, passed to a following stage |

## Verification
The bench builds the block with its default parameters: a 22-bit sum, an 8-bit code and a quantizer window starting at bit 12. With these values both clamp directions can be reached using inputs of magnitude 2^20. Two full-scale inputs in a row reach the modulo-2^22 wrap of the sum. A 4096-sample constant run shows that the loop conserves the input exactly over the whole run, not just one sample at a time. Valid-low gaps, which carry changing inputs, show that the state is held while the loop is idle.

// File: rtl/rq_pkg.sv
// Shared types for the requantizing stage.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rq_pkg;

    // Which way the quantizer resolved the current sum
    typedef enum logic [1:0] {
        Q_PASS    = 2'd0,
        Q_CLIP_HI = 2'd1,
        Q_CLIP_LO = 2'd2
    } qstat_e;

endpackage

// File: rtl/rq_quantizer.sv
// Window quantizer with amplitude clamp.
// Takes the OUT_W-bit window of the sum that starts at bit QLSB. When the
// bits above the window are not pure sign extension, the code clamps to the
// signed maximum or minimum, depending on the sign of the sum.
// Assumes: SUM_W >= QLSB + OUT_W + 1, so at least one guard bit sits above
// the window.
module rq_quantizer
    import rq_pkg::*;
#(
    parameter int SUM_W = 22,
    parameter int OUT_W = 8,
    parameter int QLSB  = 12
) (
    input  logic signed [SUM_W-1:0] sum_i,
    output logic signed [OUT_W-1:0] code_o,
    output qstat_e                  stat_o
);

    localparam int QTOP   = QLSB + OUT_W - 1;
    localparam int HEAD_W = SUM_W - QTOP;
    localparam logic signed [OUT_W-1:0] CODE_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] CODE_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HEAD_W-1:0] head;
    assign head = sum_i[SUM_W-1:QTOP];

    // Pick the window, or the clamp code when the guard bits disagree
    always_comb begin
        stat_o = Q_PASS;
        code_o = sum_i[QTOP:QLSB];
        if (head != {HEAD_W{sum_i[SUM_W-1]}}) begin
            if (sum_i[SUM_W-1]) begin
                stat_o = Q_CLIP_LO;
                code_o = CODE_MIN;
            end else begin
                stat_o = Q_CLIP_HI;
                code_o = CODE_MAX;
            end
        end
    end

endmodule

// File: rtl/rq_residual.sv
// Residual former: subtracts the chosen code, scaled back up to bit QLSB,
// from the sum. The result is the error this loop keeps for itself and hands
// on to a following stage.
// Assumes: SUM_W >= QLSB + OUT_W + 1; the residual of a clamped sum fits
// SUM_W bits.
module rq_residual #(
    parameter int SUM_W = 22,
    parameter int OUT_W = 8,
    parameter int QLSB  = 12
) (
    input  logic signed [SUM_W-1:0] sum_i,
    input  logic signed [OUT_W-1:0] code_i,
    output logic signed [SUM_W-1:0] resid_o
);

    localparam int PAD = SUM_W - OUT_W - QLSB;

    logic signed [SUM_W-1:0] code_ext;

    // Place the code back at its weight; a window at bit 0 needs no low fill
    generate
        if (QLSB > 0) begin : g_shifted
            assign code_ext = {{PAD{code_i[OUT_W-1]}}, code_i, {QLSB{1'b0}}};
        end else begin : g_unshifted
            assign code_ext = {{PAD{code_i[OUT_W-1]}}, code_i};
        end
    endgenerate

    // Error left after the code is taken out
    assign resid_o = sum_i - code_ext;

endmodule

// File: rtl/rq_stage.sv
// First-order requantizing stage. On each valid edge it adds the incoming
// error word to the stored residual, quantizes and clamps the sum to an
// OUT_W-bit code, and stores the new residual. Code and residual are both
// registered outputs. The residual output can drive the input of another
// copy of this stage.
// Assumes: synchronous active-low reset; err_i is steady around each edge.
module rq_stage
    import rq_pkg::*;
#(
    parameter int SUM_W = 22,
    parameter int OUT_W = 8,
    parameter int QLSB  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [SUM_W-1:0] err_i,
    output logic signed [OUT_W-1:0] code_o,
    output logic signed [SUM_W-1:0] resid_o
);

    localparam logic signed [OUT_W-1:0] CODE_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] CODE_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [SUM_W-1:0] acc_q;
    logic signed [OUT_W-1:0] code_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [OUT_W-1:0] code_next;
    logic signed [SUM_W-1:0] resid_next;
    qstat_e                  q_stat;

    // Loop adder; wraps at SUM_W bits
    assign sum = err_i + acc_q;

    rq_quantizer #(.SUM_W(SUM_W), .OUT_W(OUT_W), .QLSB(QLSB)) u_quant (
        .sum_i  (sum),
        .code_o (code_next),
        .stat_o (q_stat)
    );

    rq_residual #(.SUM_W(SUM_W), .OUT_W(OUT_W), .QLSB(QLSB)) u_resid (
        .sum_i   (sum),
        .code_i  (code_next),
        .resid_o (resid_next)
    );

    // Loop state and output code, advanced only by valid samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            code_q <= '0;
        end else if (in_valid) begin
            acc_q  <= resid_next;
            code_q <= code_next;
        end
    end

    assign code_o  = code_q;
    assign resid_o = acc_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0 && resid_o == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(code_o) && $stable(resid_o)));

    // R4
    clip_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_stat == Q_CLIP_HI) |=> (code_o == CODE_MAX));

    // R5
    clip_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_stat == Q_CLIP_LO) |=> (code_o == CODE_MIN));

    // R6
    resid_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_stat == Q_PASS) |=>
            (!resid_o[SUM_W-1] && (resid_o >>> QLSB) == '0));

    // R8
    code_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(rst_n)) |=> (code_o == $past(code_next)));

endmodule

// File: tb/rq_stage_tb.sv
`timescale 1ns/1ps
module rq_stage_tb;

    localparam int SUM_W = 22;
    localparam int OUT_W = 8;
    localparam int QLSB  = 12;
    localparam longint FULL = 64'sd1 <<< SUM_W;
    localparam longint HALF = 64'sd1 <<< (SUM_W - 1);
    localparam longint STEP = 64'sd1 <<< QLSB;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [SUM_W-1:0] err_i = '0;
    logic signed [OUT_W-1:0] code_o;
    logic signed [SUM_W-1:0] resid_o;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    longint m_res  = 0;
    longint m_code = 0;

    always #5 clk = ~clk;

    rq_stage #(.SUM_W(SUM_W), .OUT_W(OUT_W), .QLSB(QLSB)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .err_i    (err_i),
        .code_o   (code_o),
        .resid_o  (resid_o)
    );

    function automatic longint wrap(input longint x);
        longint m;
        m = x & (FULL - 1);
        if (m >= HALF) m = m - FULL;
        return m;
    endfunction

    task automatic compare(input string tag);
        longint a_code, a_res;
        a_code = longint'(code_o);
        a_res  = longint'(resid_o);
        n_cmp++;
        if (a_code != m_code || a_res != m_res) begin
            n_bad++;
            $display("FAIL %s: code=%0d resid=%0d expected code=%0d resid=%0d",
                     tag, a_code, a_res, m_code, m_res);
        end
    endtask

    // One clock: drive at a falling edge, model the next rising edge, check
    task automatic step(input bit v, input longint e, input string tag);
        longint s, h;
        in_valid = v;
        err_i    = e[SUM_W-1:0];
        if (v) begin
            s = wrap(wrap(e) + m_res);
            h = s >>> QLSB;
            if (h > 127) m_code = 127;
            else if (h < -128) m_code = -128;
            else m_code = h;
            m_res = s - m_code * STEP;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        err_i    = 22'sh12345;
        repeat (3) @(negedge clk);
        m_res  = 0;
        m_code = 0;
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        longint acc;
        @(negedge clk);
        do_reset();

        // R3 / R6: small constants and a ramp through the unclipped range
        for (int i = 0; i < 20; i++) step(1'b1, 1000, "R3");
        for (int i = 0; i < 64; i++) step(1'b1, -450000 + i * 14000, "R3");
        for (int i = 0; i < 200; i++)
            step(1'b1, longint'($signed($urandom_range(0, 800000))) - 400000, "R6");

        // R7: idle edges with changing input
        for (int i = 0; i < 10; i++)
            step(1'b0, longint'($signed($urandom_range(0, 4000000))) - 2000000, "R7");
        step(1'b1, 777, "R7");
        for (int i = 0; i < 5; i++) step(1'b0, -HALF, "R7");

        // R4: positive clamp
        do_reset();
        for (int i = 0; i < 6; i++) step(1'b1, 64'sd1 <<< 20, "R4");

        // R5: negative clamp
        do_reset();
        for (int i = 0; i < 6; i++) step(1'b1, -(64'sd1 <<< 20), "R5");

        // R2: wrap of the loop sum at full scale
        do_reset();
        step(1'b1, HALF - 1, "R2");
        step(1'b1, HALF - 1, "R2");
        step(1'b1, -HALF, "R2");
        step(1'b1, -HALF, "R2");

        // R8: outputs unchanged before the edge, updated after it
        do_reset();
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1;
            err_i    = 22'sd300000;
            #2;
            compare("R8");
            step(1'b1, 300000, "R8");
        end

        // R9: conservation over a long constant run
        do_reset();
        acc = 0;
        for (int i = 0; i < 4096; i++) begin
            step(1'b1, 12345, "R9");
            acc += longint'(code_o);
        end
        n_cmp++;
        if (acc * STEP + longint'(resid_o) != 4096 * 12345) begin
            n_bad++;
            $display("FAIL R9: total=%0d expected=%0d",
                     acc * STEP + longint'(resid_o), 4096 * 12345);
        end

        // R1: reset in the middle of activity
        step(1'b1, 500000, "R1");
        do_reset();
        step(1'b0, 9999, "R7");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule